// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-transfer half of a small multi-cycle processor. All movement of data happens over one shared 32-bit bus. An external sequencer chooses the single source that drives the bus in a cycle and the registers that capture it. The possible sources are the program counter, the ALU, the register file, the word memory and the sign-extended instruction offset. The sequencer itself is not part of the block.

A single bus carries only one value per cycle, so the ALU reads its two operands from holding registers A and B, and the memory address is held in a MAR. The instruction register keeps the current instruction for the whole sequence and exposes its fields to the sequencer. A zero detector on the bus and a sign capture on the ALU result give the sequencer two flags, Z and N, for its branch decisions. Neither flag can reach the bus.

Instruction field layout: opcode in bits 31:28, RA in 27:24, RB in 23:20, the offset in 19:0, and RD in 3:0 (RD overlaps the offset).

Top module: `sbus_datapath`

## Requirements
- R1: At most one drive enable is asserted in any cycle. When none is asserted, the bus carries zero.
- R2: The ALU result depends on the function code: 00 gives A+B, 01 gives the bitwise NAND of A and B, 10 gives A-B, and 11 gives A+1. The result reaches the bus only while the ALU drive enable is high.
- R3: MAR loads from the bus. A memory write stores the bus value in the word addressed by MAR bits 7:0, and the upper MAR bits are ignored. A memory read drives that word onto the bus combinationally.
- R4: IR loads from the bus only when its load strobe is high. Otherwise the IR keeps its value, and its fields appear on the outputs.
- R5: With the offset drive enable, the bus carries IR bits 19:0 sign-extended from bit 19 to 32 bits.
- R6: On the Z load strobe, Z takes 1 if the bus is all zeros and 0 if it is not. Without the strobe, Z holds its value.
- R7: On the N load strobe, N takes bit 31 of the current ALU result, whether or not the ALU drives the bus. Without the strobe, N holds its value.
- R8: The register select picks the register index: 00 selects RA, 01 selects RB, 10 selects RD and 11 selects register 0. The selected register is used both for the bus read and for the write. Register 0 always reads zero, and writes to it are discarded.
- R9: The PC loads from the bus on its strobe and keeps its value otherwise. With the PC drive enable, the PC value goes onto the bus.
- R10: A synchronous reset clears PC, A, B, MAR, IR, Z, N and registers 1 to 15. The memory is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| drv_pc | input | 1 | PC drives the bus |
| drv_alu | input | 1 | ALU result drives the bus |
| drv_reg | input | 1 | Selected register drives the bus |
| drv_mem | input | 1 | Memory word at MAR drives the bus |
| drv_off | input | 1 | Sign-extended offset drives the bus |
| ld_pc | input | 1 | PC loads from the bus |
| ld_a | input | 1 | Operand register A loads from the bus |
| ld_b | input | 1 | Operand register B loads from the bus |
| ld_mar | input | 1 | MAR loads from the bus |
| ld_ir | input | 1 | IR loads from the bus |
| ld_z | input | 1 | Z captures the bus zero test |
| ld_n | input | 1 | N captures bit 31 of the ALU result |
| wr_reg | input | 1 | Selected register is written from the bus |
| wr_mem | input | 1 | Memory word at MAR is written from the bus |
| alu_fn | input | 2 | ALU function code |
| reg_sel | input | 2 | Register index source (RA, RB, RD, zero) |
| ir_opcode | output | 4 | IR bits 31:28 |
| ir_ra | output | 4 | IR bits 27:24 |
| ir_rb | output | 4 | IR bits 23:20 |
| ir_rd | output | 4 | IR bits 3:0 |
| ir_offset | output | 20 | IR bits 19:0 |
| z_flag | output | 1 | Stored bus-zero flag |
| n_flag | output | 1 | Stored ALU sign flag |

## Verification
The bench builds arbitrary bus values only through the ALU. It doubles and increments A and B, then inverts the result with NAND. A wrong ALU code mapping would therefore corrupt nearly every later check, and random operands then point to the exact function at fault. Targeted cases go after the ends of the arithmetic range: equal operands for subtraction, which must set Z, and increments across bit 31 and across all ones. A missing sign bit or a missing carry would show up there as a wrong N or a wrong result.

Further checks cover the other corner cases:
- Writes to register 0, made both through a zero index field and through the zero select. A design without the hardwired zero would read the written value back.
- Memory addresses that differ only above bit 7. A design that decodes too many address bits would miss the aliased word.
- Negative offsets. A design that zero-extends would lose the upper ones.
- Cycles in which the load strobes are low. A design that reloads IR, Z or N without its strobe would show a changed value.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   typedef enum logic [1:0] {
      ALU_ADD  = 2'b00,
      ALU_NAND = 2'b01,
      ALU_SUB  = 2'b10,
      ALU_INC  = 2'b11
   } alu_fn_t;

   typedef enum logic [1:0] {
      SEL_RA   = 2'b00,
      SEL_RB   = 2'b01,
      SEL_RD   = 2'b10,
      SEL_ZERO = 2'b11
   } reg_sel_t;

   localparam int NUM_SOURCES = 5;

   // index of each bus source in the drive vector
   localparam int SRC_PC  = 0;
   localparam int SRC_ALU = 1;
   localparam int SRC_REG = 2;
   localparam int SRC_MEM = 3;
   localparam int SRC_OFF = 4;

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
   import sbus_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic [1:0]    fn,
   output logic [DW-1:0] result
);

   generate
      if (DW < 2) begin : g_bad_width
         $error("sbus_alu: DW must be at least 2");
      end
   endgenerate

   localparam logic [DW-1:0] ONE = DW'(1);

   alu_fn_t fn_q;
   assign fn_q = alu_fn_t'(fn);

   always_comb begin
      unique case (fn_q)
         ALU_ADD:  result = op_a + op_b;
         ALU_NAND: result = ~(op_a & op_b);
         ALU_SUB:  result = op_a - op_b;
         ALU_INC:  result = op_a + ONE;
         default:  result = '0;
      endcase
   end

endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
   parameter int DW    = 32,
   parameter int NREGS = 16,
   localparam int IW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [IW-1:0] idx,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);

   generate
      if (NREGS < 2 || (1 << IW) != NREGS) begin : g_bad_depth
         $error("sbus_regfile: NREGS must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] regs [NREGS];

   genvar gi;
   generate
      for (gi = 0; gi < NREGS; gi++) begin : g_reg
         if (gi == 0) begin : g_zero
            assign regs[gi] = '0;
         end else begin : g_flop
            always_ff @(posedge clk) begin
               if (rst)
                  regs[gi] <= '0;
               else if (wr_en && idx == IW'(gi))
                  regs[gi] <= wr_data;
            end
         end
      end
   endgenerate

   assign rd_data = regs[idx];

   // R8: entry zero never yields anything but zero
   a_r8_zero_reads_zero: assert property (@(posedge clk) disable iff (rst)
      (idx == '0) |-> (rd_data == '0));

   // R8: a write to a nonzero entry is visible on the next read of it
   a_r8_write_visible: assert property (@(posedge clk) disable iff (rst)
      (wr_en && idx != '0) |=> ((idx != $past(idx)) || (rd_data == $past(wr_data))));

endmodule

// File: rtl/sbus_memory.sv
module sbus_memory #(
   parameter int DW    = 32,
   parameter int WORDS = 256,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);

   generate
      if (WORDS < 2 || (1 << AW) != WORDS) begin : g_bad_words
         $error("sbus_memory: WORDS must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] store [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en)
         store[addr] <= wr_data;
   end

   assign rd_data = store[addr];

   // R3: written word reads back at the same address on the next cycle
   a_r3_write_then_read: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((addr != $past(addr)) || (rd_data == $past(wr_data))));

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
   import sbus_pkg::*;
#(
   parameter int DW        = 32,
   parameter int NREGS     = 16,
   parameter int MEM_WORDS = 256,
   parameter int OFF_W     = 20,
   parameter int OPC_W     = 4,
   localparam int IW       = $clog2(NREGS),
   localparam int MAW      = $clog2(MEM_WORDS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             drv_pc,
   input  logic             drv_alu,
   input  logic             drv_reg,
   input  logic             drv_mem,
   input  logic             drv_off,
   input  logic             ld_pc,
   input  logic             ld_a,
   input  logic             ld_b,
   input  logic             ld_mar,
   input  logic             ld_ir,
   input  logic             ld_z,
   input  logic             ld_n,
   input  logic             wr_reg,
   input  logic             wr_mem,
   input  logic [1:0]       alu_fn,
   input  logic [1:0]       reg_sel,
   output logic [OPC_W-1:0] ir_opcode,
   output logic [IW-1:0]    ir_ra,
   output logic [IW-1:0]    ir_rb,
   output logic [IW-1:0]    ir_rd,
   output logic [OFF_W-1:0] ir_offset,
   output logic             z_flag,
   output logic             n_flag
);

   // instruction field positions
   localparam int OPC_LSB = DW - OPC_W;
   localparam int RA_LSB  = OPC_LSB - IW;
   localparam int RB_LSB  = RA_LSB - IW;
   localparam int EXT_W   = DW - OFF_W;

   generate
      if (RB_LSB < OFF_W) begin : g_bad_fields
         $error("sbus_datapath: opcode, two indices and offset exceed DW");
      end
      if (MAW > DW) begin : g_bad_mem
         $error("sbus_datapath: memory address wider than MAR");
      end
      if (IW > OFF_W) begin : g_bad_rd
         $error("sbus_datapath: RD field does not fit in offset");
      end
   endgenerate

   // ---------------- state ----------------
   logic [DW-1:0] pc_q, a_q, b_q, mar_q, ir_q;
   logic          z_q, n_q;

   // ---------------- bus sources ----------------
   logic [DW-1:0] alu_y, reg_rd, mem_rd, off_ext;
   logic [DW-1:0] src     [NUM_SOURCES];
   logic [NUM_SOURCES-1:0] drv_vec;
   logic [DW-1:0] bus;

   assign drv_vec[SRC_PC]  = drv_pc;
   assign drv_vec[SRC_ALU] = drv_alu;
   assign drv_vec[SRC_REG] = drv_reg;
   assign drv_vec[SRC_MEM] = drv_mem;
   assign drv_vec[SRC_OFF] = drv_off;

   assign src[SRC_PC]  = pc_q;
   assign src[SRC_ALU] = alu_y;
   assign src[SRC_REG] = reg_rd;
   assign src[SRC_MEM] = mem_rd;
   assign src[SRC_OFF] = off_ext;

   // gated OR: each source contributes only while enabled
   always_comb begin
      bus = '0;
      for (int i = 0; i < NUM_SOURCES; i++)
         bus = bus | (src[i] & {DW{drv_vec[i]}});
   end

   // ---------------- offset sign extension ----------------
   assign off_ext = {{EXT_W{ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

   // ---------------- register index select ----------------
   reg_sel_t      sel_q;
   logic [IW-1:0] reg_idx;
   assign sel_q = reg_sel_t'(reg_sel);

   always_comb begin
      unique case (sel_q)
         SEL_RA:   reg_idx = ir_q[RA_LSB +: IW];
         SEL_RB:   reg_idx = ir_q[RB_LSB +: IW];
         SEL_RD:   reg_idx = ir_q[IW-1:0];
         SEL_ZERO: reg_idx = '0;
         default:  reg_idx = '0;
      endcase
   end

   // ---------------- sub-blocks ----------------
   sbus_alu #(.DW(DW)) u_alu (
      .op_a   (a_q),
      .op_b   (b_q),
      .fn     (alu_fn),
      .result (alu_y)
   );

   sbus_regfile #(.DW(DW), .NREGS(NREGS)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .idx     (reg_idx),
      .wr_en   (wr_reg),
      .wr_data (bus),
      .rd_data (reg_rd)
   );

   logic [MAW-1:0] mem_addr;
   assign mem_addr = mar_q[MAW-1:0];

   generate
      if (MAW < DW) begin : g_mar_hi
         logic unused_mar_hi;
         assign unused_mar_hi = ^mar_q[DW-1:MAW];
      end
   endgenerate

   sbus_memory #(.DW(DW), .WORDS(MEM_WORDS)) u_mem (
      .clk     (clk),
      .rst     (rst),
      .addr    (mem_addr),
      .wr_en   (wr_mem),
      .wr_data (bus),
      .rd_data (mem_rd)
   );

   // ---------------- bus-loaded registers ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         mar_q <= '0;
         ir_q  <= '0;
         z_q   <= 1'b0;
         n_q   <= 1'b0;
      end else begin
         if (ld_pc)  pc_q  <= bus;
         if (ld_a)   a_q   <= bus;
         if (ld_b)   b_q   <= bus;
         if (ld_mar) mar_q <= bus;
         if (ld_ir)  ir_q  <= bus;
         if (ld_z)   z_q   <= (bus == '0);
         if (ld_n)   n_q   <= alu_y[DW-1];
      end
   end

   // ---------------- outputs ----------------
   assign ir_opcode = ir_q[OPC_LSB +: OPC_W];
   assign ir_ra     = ir_q[RA_LSB +: IW];
   assign ir_rb     = ir_q[RB_LSB +: IW];
   assign ir_rd     = ir_q[IW-1:0];
   assign ir_offset = ir_q[OFF_W-1:0];
   assign z_flag    = z_q;
   assign n_flag    = n_q;

   // ---------------- assertions ----------------
   // R1: never two drivers at once
   a_r1_one_driver: assert property (@(posedge clk) disable iff (rst)
      $countones(drv_vec) <= 1);

   // R1: undriven bus is zero
   a_r1_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
      (drv_vec == '0) |-> (bus == '0));

   // R4: IR holds without its strobe
   a_r4_ir_hold: assert property (@(posedge clk) disable iff (rst)
      !ld_ir |=> $stable(ir_q));

   // R6: Z reflects the bus of the capture cycle, and holds otherwise
   a_r6_z_capture: assert property (@(posedge clk) disable iff (rst)
      ld_z |=> (z_flag == ($past(bus) == '0)));
   a_r6_z_hold: assert property (@(posedge clk) disable iff (rst)
      !ld_z |=> $stable(z_flag));

   // R7: N holds without its strobe
   a_r7_n_hold: assert property (@(posedge clk) disable iff (rst)
      !ld_n |=> $stable(n_flag));

   // R9: PC holds without its strobe
   a_r9_pc_hold: assert property (@(posedge clk) disable iff (rst)
      !ld_pc |=> $stable(pc_q));

endmodule

// File: tb/sbus_datapath_bench.sv
`timescale 1ns/1ps
module sbus_datapath_bench;

   logic clk = 1'b0;
   logic rst;
   logic drv_pc, drv_alu, drv_reg, drv_mem, drv_off;
   logic ld_pc, ld_a, ld_b, ld_mar, ld_ir, ld_z, ld_n, wr_reg, wr_mem;
   logic [1:0] alu_fn, reg_sel;
   logic [3:0] ir_opcode, ir_ra, ir_rb, ir_rd;
   logic [19:0] ir_offset;
   logic z_flag, n_flag;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sbus_datapath u_sbus_datapath (
      .clk(clk), .rst(rst),
      .drv_pc(drv_pc), .drv_alu(drv_alu), .drv_reg(drv_reg),
      .drv_mem(drv_mem), .drv_off(drv_off),
      .ld_pc(ld_pc), .ld_a(ld_a), .ld_b(ld_b), .ld_mar(ld_mar),
      .ld_ir(ld_ir), .ld_z(ld_z), .ld_n(ld_n),
      .wr_reg(wr_reg), .wr_mem(wr_mem),
      .alu_fn(alu_fn), .reg_sel(reg_sel),
      .ir_opcode(ir_opcode), .ir_ra(ir_ra), .ir_rb(ir_rb), .ir_rd(ir_rd),
      .ir_offset(ir_offset), .z_flag(z_flag), .n_flag(n_flag)
   );

   // sources
   localparam int S_NONE = 0, S_PC = 1, S_ALU = 2, S_REG = 3, S_MEM = 4, S_OFF = 5;
   // load mask bits
   localparam logic [8:0] M_PC = 9'h100, M_A = 9'h080, M_B = 9'h040, M_MAR = 9'h020,
                          M_IR = 9'h010, M_Z = 9'h008, M_N = 9'h004, M_WREG = 9'h002,
                          M_WMEM = 9'h001, M_NONE = 9'h000;
   localparam logic [1:0] F_ADD = 2'b00, F_NAND = 2'b01, F_SUB = 2'b10, F_INC = 2'b11;
   localparam logic [1:0] G_RA = 2'b00, G_RB = 2'b01, G_RD = 2'b10, G_ZERO = 2'b11;

   task automatic idle_ctl();
      {drv_pc, drv_alu, drv_reg, drv_mem, drv_off} = '0;
      {ld_pc, ld_a, ld_b, ld_mar, ld_ir, ld_z, ld_n, wr_reg, wr_mem} = '0;
      alu_fn = 2'b00;
      reg_sel = 2'b00;
   endtask

   task automatic cyc(input int src, input logic [8:0] m, input logic [1:0] fn,
                      input logic [1:0] sel);
      @(negedge clk);
      drv_pc  = (src == S_PC);
      drv_alu = (src == S_ALU);
      drv_reg = (src == S_REG);
      drv_mem = (src == S_MEM);
      drv_off = (src == S_OFF);
      {ld_pc, ld_a, ld_b, ld_mar, ld_ir, ld_z, ld_n, wr_reg, wr_mem} = m;
      alu_fn  = fn;
      reg_sel = sel;
      @(posedge clk);
      #1;
      idle_ctl();
   endtask

   // builds ~v in A and B by doubling and incrementing, then NAND puts v on the bus
   task automatic put_value(input logic [31:0] v, input logic [8:0] m, input logic [1:0] sel);
      logic [31:0] nv;
      nv = ~v;
      cyc(S_NONE, M_A | M_B, F_ADD, G_RA);
      for (int i = 31; i >= 0; i--) begin
         cyc(S_ALU, M_A | M_B, F_ADD, G_RA);
         if (nv[i]) cyc(S_ALU, M_A | M_B, F_INC, G_RA);
      end
      cyc(S_ALU, m, F_NAND, sel);
   endtask

   function automatic logic [31:0] ir_word();
      return {ir_opcode, ir_ra, ir_rb, ir_offset};
   endfunction

   task automatic observe(input int src, input logic [1:0] fn, input logic [1:0] sel,
                          output logic [31:0] val);
      cyc(src, M_IR, fn, sel);
      val = ir_word();
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] alu_model(input logic [1:0] fn, input logic [31:0] a,
                                             input logic [31:0] b);
      case (fn)
         F_ADD:   return a + b;
         F_NAND:  return ~(a & b);
         F_SUB:   return a - b;
         default: return a + 32'd1;
      endcase
   endfunction

   function automatic logic [31:0] instr(input logic [3:0] ra, input logic [3:0] rb,
                                         input logic [3:0] rd);
      return {4'h5, ra, rb, 16'h0, rd};
   endfunction

   // one ALU trial: r1=a, r2=b, load A/B, run fn with N and Z capture
   task automatic alu_trial(input logic [1:0] fn, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] got, exp;
      put_value(instr(4'd1, 4'd2, 4'd0), M_IR, G_RA);
      put_value(a, M_WREG, G_RA);
      put_value(b, M_WREG, G_RB);
      cyc(S_REG, M_A, F_ADD, G_RA);
      cyc(S_REG, M_B, F_ADD, G_RB);
      cyc(S_ALU, M_IR | M_N | M_Z, fn, G_RA);
      got = ir_word();
      exp = alu_model(fn, a, b);
      check("R2 alu result", got, exp);
      check("R7 n capture", {31'b0, n_flag}, {31'b0, exp[31]});
      check("R6 z capture", {31'b0, z_flag}, {31'b0, (exp == 32'b0)});
   endtask

   logic [31:0] mem_model [256];
   logic        mem_valid [256];

   initial begin : watchdog
      #750000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] got, v, a, b, addr;
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_1234);
      for (int i = 0; i < 256; i++) mem_valid[i] = 1'b0;
      idle_ctl();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;

      // R10: reset state
      check("R10 ir after reset", ir_word(), 32'h0);
      check("R10 flags after reset", {30'b0, z_flag, n_flag}, 32'h0);
      observe(S_PC, F_ADD, G_RA, got);
      check("R10 pc after reset", got, 32'h0);
      put_value(instr(4'd9, 4'd9, 4'd9), M_IR, G_RA);
      observe(S_REG, F_ADD, G_RA, got);
      check("R10 register 9 after reset", got, 32'h0);

      // R1: undriven bus is zero
      put_value(32'hDEAD_BEEF, M_IR, G_RA);
      check("R1 ir preload", ir_word(), 32'hDEAD_BEEF);
      observe(S_NONE, F_ADD, G_RA, got);
      check("R1 idle bus", got, 32'h0);

      // R2 directed corners
      alu_trial(F_SUB, 32'h1234_5678, 32'h1234_5678);
      alu_trial(F_INC, 32'h7FFF_FFFF, 32'h0);
      alu_trial(F_INC, 32'hFFFF_FFFF, 32'h0);
      alu_trial(F_ADD, 32'h8000_0000, 32'h8000_0000);
      alu_trial(F_NAND, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      alu_trial(F_SUB, 32'h0, 32'h1);
      // R2: result stays off the bus without drive enable
      observe(S_NONE, F_INC, G_RA, got);
      check("R2 alu not driving", got, 32'h0);

      // R2 random
      for (int k = 0; k < 40; k++) begin
         a = $urandom();
         b = $urandom();
         alu_trial(2'(k % 4), a, b);
      end

      // R6 / R7 hold without strobe
      put_value(32'h0, M_Z, G_RA);
      check("R6 z set on zero bus", {31'b0, z_flag}, 32'h1);
      put_value(32'h0000_0040, M_NONE, G_RA);
      check("R6 z holds", {31'b0, z_flag}, 32'h1);
      put_value(32'h0000_0040, M_Z, G_RA);
      check("R6 z clear on nonzero bus", {31'b0, z_flag}, 32'h0);
      alu_trial(F_SUB, 32'h1, 32'h2);
      put_value(32'h0000_0001, M_NONE, G_RA);
      check("R7 n holds", {31'b0, n_flag}, 32'h1);

      // R4: IR hold through unrelated traffic
      put_value(32'hA1B2_C3D4, M_IR, G_RA);
      put_value(32'h1111_2222, M_PC | M_MAR, G_RA);
      cyc(S_PC, M_A, F_ADD, G_RA);
      check("R4 ir holds", ir_word(), 32'hA1B2_C3D4);
      check("R4 rd field", {28'b0, ir_rd}, 32'h4);

      // R5: sign extension
      put_value(32'h0008_1234, M_IR, G_RA);
      observe(S_OFF, F_ADD, G_RA, got);
      check("R5 negative offset", got, 32'hFFF8_1234);
      put_value(32'hF007_FFFF, M_IR, G_RA);
      observe(S_OFF, F_ADD, G_RA, got);
      check("R5 positive offset", got, 32'h0007_FFFF);

      // R9: PC load and drive
      put_value(32'h0BAD_F00D, M_PC, G_RA);
      cyc(S_NONE, M_A, F_ADD, G_RA);
      observe(S_PC, F_ADD, G_RA, got);
      check("R9 pc readback", got, 32'h0BAD_F00D);

      // R8: register 0 and select modes
      put_value(instr(4'd0, 4'd5, 4'd7), M_IR, G_RA);
      put_value(32'h5555_AAAA, M_WREG, G_RA);
      put_value(32'h3333_CCCC, M_WREG, G_ZERO);
      put_value(32'h0F0F_0F0F, M_WREG, G_RB);
      put_value(32'h7777_0001, M_WREG, G_RD);
      cyc(S_REG, M_A, F_ADD, G_RA);
      cyc(S_REG, M_B, F_ADD, G_ZERO);
      cyc(S_ALU, M_IR, F_ADD, G_RA);
      check("R8 r0 via RA and zero select", ir_word(), 32'h0);
      put_value(instr(4'd0, 4'd5, 4'd7), M_IR, G_RA);
      observe(S_REG, F_ADD, G_RB, got);
      check("R8 rb select", got, 32'h0F0F_0F0F);
      put_value(instr(4'd0, 4'd5, 4'd7), M_IR, G_RA);
      observe(S_REG, F_ADD, G_RD, got);
      check("R8 rd select", got, 32'h7777_0001);

      // R3: memory, including aliasing above bit 7
      for (int k = 0; k < 12; k++) begin
         addr = $urandom();
         v = $urandom();
         put_value(addr, M_MAR, G_RA);
         put_value(v, M_WMEM, G_RA);
         mem_model[addr[7:0]] = v;
         mem_valid[addr[7:0]] = 1'b1;
      end
      put_value(32'h0000_0013, M_MAR, G_RA);
      put_value(32'hCAFE_0013, M_WMEM, G_RA);
      mem_model[8'h13] = 32'hCAFE_0013;
      mem_valid[8'h13] = 1'b1;
      put_value(32'hFFFF_FF13, M_MAR, G_RA);
      observe(S_MEM, F_ADD, G_RA, got);
      check("R3 alias above bit 7", got, 32'hCAFE_0013);
      for (int i = 0; i < 256; i++) begin
         if (mem_valid[i]) begin
            put_value(32'(i) | 32'h0100_0000, M_MAR, G_RA);
            observe(S_MEM, F_ADD, G_RA, got);
            check("R3 memory readback", got, mem_model[i]);
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
   end

endmodule